// File: doc/BRIEF.md
# Trigger Window Hit Acceptance

This block keeps a small set of trigger windows on a shared, free-running time-stamp counter. It decides whether each detected hit overlaps any of them. A trigger strobe opens a window that starts a programmable offset after the current time stamp and lasts a programmable width. Several windows may be open at once, and their ranges may overlap. The window is stored in the lowest-numbered free slot and stays there until the time stamp has moved past its end plus the resolving time.

Each hit arrives with a time value from an upstream hit detector. Around that time the block builds an accept window that reaches the coarse resolving time to each side. One comparator channel per slot tests this window against the slot's trigger window. The block then issues a one-cycle accept pulse and the index of the lowest matching slot. All time arithmetic is modular on the counter width, so windows that cross the counter wrap work the same as any other.

Top module: `trig_win_accept`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `accept` and `accept_idx` are 0 and every slot is free.
- R2: A trigger sampled with time stamp T, offset O and width W opens the window [T+O, T+O+W], with both bounds inclusive and computed modulo 2^16.
- R3: A trigger takes the lowest-numbered free slot. When all four slots are occupied the trigger is ignored: it opens no window.
- R4: A hit with time H and resolving time R forms the accept window [H-R, H+R]. With R = 0 this is the single point H.
- R5: A slot matches when the accept window and its trigger window intersect, with both ends inclusive.
- R6: For a hit strobe sampled at clock edge k, `accept` is valid after edge k+1 and lasts one cycle per hit. The hit is compared against the slots as they stand after edge k.
- R7: When several slots match, `accept_idx` gives the lowest matching slot number as a binary value from 0 to 3. When `accept` is low, `accept_idx` is 0.
- R8: A slot is freed at the first edge where the time stamp is later than its end plus R. After that it no longer matches hits and a new trigger can reuse it.
- R9: A window or accept window that spans the counter wrap from 0xFFFF to 0x0000 compares correctly, as long as every distance involved is below 2^15.
- R10: A hit that overlaps no open window leaves `accept` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ts | input | 16 | Free-running time-stamp counter |
| trig_stb | input | 1 | Trigger strobe, one cycle per trigger |
| trig_ofs | input | 16 | Delay from the current time stamp to the window start |
| trig_wid | input | 16 | Window length in counts |
| hit_stb | input | 1 | Hit strobe, one cycle per hit |
| hit_time | input | 16 | Time value of the hit |
| res_time | input | 16 | Coarse resolving time, applied to each side |
| accept | output | 1 | One-cycle pulse: the hit overlaps an open window |
| accept_idx | output | 2 | Lowest matching slot number |

## Verification
Some rules are checked on every cycle by the assertions. A slot is freed once its end plus the resolving time has passed. A trigger grows the live-slot count by exactly one, except when all slots are full, in which case the stored windows stay unchanged. An accept pulse only follows a hit by two edges and always points at a slot that was live. The accept window is always symmetric around the hit time. Some behaviours can only be shown by the bench's scenarios with known expected values. These are the inclusive edges of the overlap test, resolving time zero, windows across the counter wrap, lowest-index priority among overlapping windows, a fifth trigger being dropped, and a freed slot being reused.

// File: rtl/twa_pkg.sv
package twa_pkg;
  localparam int TS_W = 16;
  localparam int NWIN = 4;

  typedef logic [TS_W-1:0] ts_t;

  typedef struct packed {
    ts_t lo;
    ts_t hi;
  } span_t;

  // a <= b on a wrapping counter: true when b-a is non-negative as a signed value
  function automatic logic ts_le(ts_t a, ts_t b);
    ts_t d;
    d = b - a;
    return ~d[TS_W-1];
  endfunction
endpackage

// File: rtl/twa_slots.sv
module twa_slots import twa_pkg::*; #(
  parameter int NW = NWIN
) (
  input  logic              clk,
  input  logic              rst,
  input  ts_t               ts,
  input  logic              trig_stb,
  input  ts_t               trig_ofs,
  input  ts_t               trig_wid,
  input  ts_t               res_time,
  output logic [NW-1:0]     live,
  output span_t [NW-1:0]    win
);
  localparam int IW = (NW > 1) ? $clog2(NW) : 1;

  logic [NW-1:0] gone;
  logic          found;
  logic [IW-1:0] pick;
  ts_t           new_lo;

  assign new_lo = ts + trig_ofs;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NW - 1; i >= 0; i--) begin
      if (!live[i]) begin
        found = 1'b1;
        pick  = IW'(i);
      end
    end
  end

  for (genvar g = 0; g < NW; g++) begin : g_rel
    ts_t limit;
    assign limit   = win[g].hi + res_time;
    assign gone[g] = live[g] && !ts_le(ts, limit);

    assert_release_R8: assert property (@(posedge clk) disable iff (rst)
      live[g] && !ts_le(ts, win[g].hi + res_time) |=> !live[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
    end else begin
      for (int i = 0; i < NW; i++) begin
        if (gone[i]) live[i] <= 1'b0;
      end
      if (trig_stb && found) begin
        live[pick]   <= 1'b1;
        win[pick].lo <= new_lo;
        win[pick].hi <= new_lo + trig_wid;
      end
    end
  end

  assert_alloc_grows_R3: assert property (@(posedge clk) disable iff (rst)
    trig_stb && !(&live) |=> $countones(live) == $countones($past(live & ~gone)) + 1);

  assert_full_ignore_R3: assert property (@(posedge clk) disable iff (rst)
    trig_stb && (&live) |=> $stable(win));
endmodule

// File: rtl/twa_acc_win.sv
module twa_acc_win import twa_pkg::*; (
  input  logic  clk,
  input  logic  rst,
  input  logic  hit_stb,
  input  ts_t   hit_time,
  input  ts_t   res_time,
  output logic  acc_v,
  output span_t acc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_v <= 1'b0;
      acc   <= '0;
    end else begin
      acc_v <= hit_stb;
      if (hit_stb) begin
        acc.lo <= hit_time - res_time;
        acc.hi <= hit_time + res_time;
      end
    end
  end

  assert_span_sym_R4: assert property (@(posedge clk) disable iff (rst)
    hit_stb |=> acc_v && (ts_t'(acc.hi - acc.lo) == ts_t'($past(res_time) << 1)));
endmodule

// File: rtl/twa_chan_cmp.sv
module twa_chan_cmp import twa_pkg::*; (
  input  logic  live,
  input  span_t win,
  input  span_t acc,
  output logic  match
);
  assign match = live && ts_le(acc.lo, win.hi) && ts_le(win.lo, acc.hi);
endmodule

// File: rtl/trig_win_accept.sv
module trig_win_accept import twa_pkg::*; #(
  parameter int NW = NWIN,
  localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TS_W-1:0] ts,
  input  logic            trig_stb,
  input  logic [TS_W-1:0] trig_ofs,
  input  logic [TS_W-1:0] trig_wid,
  input  logic            hit_stb,
  input  logic [TS_W-1:0] hit_time,
  input  logic [TS_W-1:0] res_time,
  output logic            accept,
  output logic [IW-1:0]   accept_idx
);
  logic [NW-1:0]  live;
  span_t [NW-1:0] win;
  logic           acc_v;
  span_t          acc;
  logic [NW-1:0]  match;
  logic [IW-1:0]  first;

  twa_slots #(.NW(NW)) i_slots (
    .clk(clk), .rst(rst), .ts(ts), .trig_stb(trig_stb),
    .trig_ofs(trig_ofs), .trig_wid(trig_wid), .res_time(res_time),
    .live(live), .win(win)
  );

  twa_acc_win i_accw (
    .clk(clk), .rst(rst), .hit_stb(hit_stb), .hit_time(hit_time),
    .res_time(res_time), .acc_v(acc_v), .acc(acc)
  );

  for (genvar g = 0; g < NW; g++) begin : g_chan
    twa_chan_cmp i_cmp (
      .live(live[g]), .win(win[g]), .acc(acc), .match(match[g])
    );
  end

  always_comb begin
    first = '0;
    for (int i = NW - 1; i >= 0; i--) begin
      if (match[i]) first = IW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accept     <= 1'b0;
      accept_idx <= '0;
    end else begin
      accept     <= acc_v && (|match);
      accept_idx <= (acc_v && (|match)) ? first : '0;
    end
  end

  assert_accept_after_hit_R6: assert property (@(posedge clk) disable iff (rst)
    accept |-> $past(hit_stb, 2));

  assert_idx_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !accept |-> accept_idx == '0);

  assert_idx_live_R5: assert property (@(posedge clk) disable iff (rst)
    accept |-> |($past(live) & (NW'(1) << accept_idx)));

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !accept && accept_idx == '0);
endmodule

// File: tb/test_trig_win_accept.sv
`timescale 1ns/1ps
module test_trig_win_accept;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ts = '0;
  logic        trig_stb = 1'b0;
  logic [15:0] trig_ofs = '0, trig_wid = '0;
  logic        hit_stb = 1'b0;
  logic [15:0] hit_time = '0, res_time = '0;
  logic        accept;
  logic [1:0]  accept_idx;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  trig_win_accept i_trig_win_accept (
    .clk(clk), .rst(rst), .ts(ts), .trig_stb(trig_stb), .trig_ofs(trig_ofs),
    .trig_wid(trig_wid), .hit_stb(hit_stb), .hit_time(hit_time),
    .res_time(res_time), .accept(accept), .accept_idx(accept_idx)
  );

  typedef struct packed {
    logic [15:0] t0, ofs, wid, res, hit;
    logic        acc;
  } vec_t;

  localparam vec_t VEC [15] = '{
    '{16'd1000, 16'd100, 16'd50, 16'd4, 16'd1120, 1'b1},
    '{16'd1000, 16'd100, 16'd50, 16'd4, 16'd1096, 1'b1},
    '{16'd1000, 16'd100, 16'd50, 16'd4, 16'd1095, 1'b0},
    '{16'd1000, 16'd100, 16'd50, 16'd4, 16'd1154, 1'b1},
    '{16'd1000, 16'd100, 16'd50, 16'd4, 16'd1155, 1'b0},
    '{16'd1000, 16'd100, 16'd50, 16'd0, 16'd1100, 1'b1},
    '{16'd1000, 16'd100, 16'd50, 16'd0, 16'd1099, 1'b0},
    '{16'd1000, 16'd100, 16'd50, 16'd0, 16'd1150, 1'b1},
    '{16'hFFF0, 16'h0020, 16'h0010, 16'd3, 16'h000D, 1'b1},
    '{16'hFFF0, 16'h0020, 16'h0010, 16'd3, 16'h000C, 1'b0},
    '{16'hFF00, 16'h00F0, 16'h0040, 16'd2, 16'h0005, 1'b1},
    '{16'hFF00, 16'h00F0, 16'h0040, 16'd2, 16'h0032, 1'b1},
    '{16'hFF00, 16'h00F0, 16'h0040, 16'd2, 16'h0033, 1'b0},
    '{16'hFF00, 16'h00F0, 16'h0040, 16'd2, 16'hFFEE, 1'b1},
    '{16'hFF00, 16'h00F0, 16'h0040, 16'd2, 16'hFFED, 1'b0}
  };

  task automatic step();
    @(negedge clk);
    ts = ts + 16'd1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [15:0] t0);
    rst = 1'b1;
    step();
    step();
    rst = 1'b0;
    ts = t0;
  endtask

  task automatic trig(logic [15:0] o, logic [15:0] w);
    trig_stb = 1'b1;
    trig_ofs = o;
    trig_wid = w;
    step();
    trig_stb = 1'b0;
  endtask

  task automatic hit_check(logic [15:0] h, logic ea, logic [1:0] ei, string req);
    hit_stb  = 1'b1;
    hit_time = h;
    step();
    hit_stb = 1'b0;
    chk({req, " R6 early"}, {31'd0, accept}, 32'd0);
    step();
    chk({req, " accept"}, {31'd0, accept}, {31'd0, ea});
    chk({req, " R7 idx"}, {30'd0, accept_idx}, {30'd0, ei});
    step();
    chk({req, " R6 one pulse"}, {31'd0, accept}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    step();
    chk("R1 accept in reset", {31'd0, accept}, 32'd0);
    chk("R1 idx in reset", {30'd0, accept_idx}, 32'd0);
    do_reset(16'd500);
    res_time = 16'd100;
    chk("R1 accept after reset", {31'd0, accept}, 32'd0);
    hit_check(16'd500, 1'b0, 2'd0, "R1 no slot live");

    // table walk: one trigger per vector, so slot 0 is expected (R2 R4 R5 R9 R10)
    for (int k = 0; k < 15; k++) begin
      do_reset(VEC[k].t0);
      res_time = VEC[k].res;
      trig(VEC[k].ofs, VEC[k].wid);
      hit_check(VEC[k].hit, VEC[k].acc, 2'd0, $sformatf("R2 R5 R9 vec%0d", k));
    end

    // priority, full slots and release
    do_reset(16'd2000);
    res_time = 16'd2;
    trig(16'd10, 16'd5);     // slot 0: 2010..2015
    trig(16'd99, 16'd20);    // slot 1: 2100..2120
    trig(16'd108, 16'd40);   // slot 2: 2110..2150
    trig(16'd297, 16'd10);   // slot 3: 2300..2310
    trig(16'd496, 16'd10);   // dropped, would be 2500..2510
    hit_check(16'd2012, 1'b1, 2'd0, "R3 slot0");
    hit_check(16'd2140, 1'b1, 2'd2, "R3 slot2 only");
    hit_check(16'd2115, 1'b1, 2'd1, "R7 lowest of 1,2");
    hit_check(16'd2305, 1'b1, 2'd3, "R3 fourth slot");
    hit_check(16'd2505, 1'b0, 2'd0, "R3 fifth ignored");
    hit_check(16'd2012, 1'b0, 2'd0, "R8 slot0 freed");
    trig(16'd2600 - ts, 16'd10);
    hit_check(16'd2605, 1'b1, 2'd0, "R8 slot0 reused");
    hit_check(16'd2115, 1'b1, 2'd1, "R8 slot1 kept");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule